// File: doc/BRIEF.md
# Timer Legacy Interrupt Router

This block sits between a multi-timer event counter and a bank of interrupt request lines. Each timer presents an interrupt level and a route number. The route number picks one of the output lines, and the timer's level drives that line. A global legacy-routing enable changes this for the two lowest timers. While it is set, timer 0 is tied to line 0 and timer 1 to line 8, and their route numbers no longer matter.

The block also intercepts the interrupt output of a real-time clock, which normally owns line 8. A one-bit register records the clock's level on every clock edge, in either mode. While legacy routing is off, the clock level passes to line 8. While legacy routing is on, the clock contribution is held low. When legacy routing is switched off again, line 8 is loaded from the recorded level. After that, the live level drives it again.

Every output is registered, so a line reflects its inputs one clock edge after they are applied. The reset is synchronous and active high.

Top module: `timer_irq_router`

## Requirements
- R1: While reset is high, every output line reads 0 after the next clock edge, and the recorded clock level and the previous legacy bit are both cleared to 0.
- R2: With legacy routing off, a timer whose level is 1 and whose route number r is below 24 drives line r high one edge later. A line is high when any of its sources is high, which makes it an OR of those sources.
- R3: With legacy routing on, timer 0 drives line 0 and timer 1 drives line 8 one edge later, and the route numbers of these two timers have no effect.
- R4: Timers 2 and above use their route number in both modes.
- R5: With legacy routing off both on this edge and on the previous edge, line 8 receives the current clock interrupt level, ORed with any timer routed to line 8.
- R6: When the legacy bit rises, and on every edge while it stays 1, the clock contributes 0 to line 8. Only timer sources can drive that line.
- R7: On the first edge after the legacy bit falls, the clock's contribution to line 8 is the level recorded on the previous edge. That level is recorded every edge, including while legacy routing was on.
- R8: A route number of 24 or above drives no line. Route numbers are 5 bits wide, and timer t uses bits [5t+4:5t] of the route bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacyEn | input | 1 | Global legacy-routing enable |
| rtcIrq | input | 1 | Real-time clock interrupt level |
| timerIrq | input | 4 | Per-timer interrupt levels, bit t is timer t |
| timerRoute | input | 20 | Per-timer route numbers, 5 bits each |
| irqLines | output | 24 | Registered interrupt request lines |

## Verification
The hardest case to reach is the restore edge. A correct design and a plain pass-through give different answers there only when the clock level changes in the same cycle that the legacy bit falls. The stimulus therefore holds legacy on while it sets the clock level, then drops legacy and flips the clock level together, in both polarities. Random stimulus keeps the legacy bit switching often, which produces many rise and fall edges with all timers quiet. In those cycles the clock path alone is visible on line 8.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
  typedef struct packed {
    logic legacyOn;
    logic legacyRise;
    logic legacyFall;
    logic heldLevel;
  } tlrCtrl_t;
endpackage

// File: rtl/tlr_ctrl.sv
module tlr_ctrl
  import tlr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     legacyEn,
  input  logic     rtcIrq,
  output tlrCtrl_t ctrlS
);
  logic legacyQ;
  logic rtcLevelQ;

  // previous legacy bit and last clock level, recorded every edge
  always_ff @(posedge clk) begin
    if (rst) begin
      legacyQ   <= 1'b0;
      rtcLevelQ <= 1'b0;
    end else begin
      legacyQ   <= legacyEn;
      rtcLevelQ <= rtcIrq;
    end
  end

  always_comb begin
    ctrlS.legacyOn   = legacyEn;
    ctrlS.legacyRise = legacyEn & ~legacyQ;
    ctrlS.legacyFall = ~legacyEn & legacyQ;
    ctrlS.heldLevel  = rtcLevelQ;
  end
endmodule

// File: rtl/tlr_datapath.sv
module tlr_datapath
  import tlr_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_LINES  = 24,
  parameter int ROUTE_W    = 5,
  parameter int T0_LINE    = 0,
  parameter int CLK_LINE   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  tlrCtrl_t                      ctrlS,
  input  logic                          rtcIrq,
  input  logic [NUM_TIMERS-1:0]         timerIrq,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] timerRoute,
  output logic [NUM_LINES-1:0]          irqLines
);
  localparam int LEGACY_TIMERS = 2;

  logic [ROUTE_W-1:0]   effRoute [NUM_TIMERS];
  logic [NUM_LINES-1:0] hitVec   [NUM_TIMERS];
  logic [NUM_LINES-1:0] timerOr;
  logic [NUM_LINES-1:0] clockVec;
  logic                 clkNext;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    if (t < LEGACY_TIMERS) begin : g_legacy
      localparam int FIXED_LINE = (t == 0) ? T0_LINE : CLK_LINE;
      assign effRoute[t] = ctrlS.legacyOn ? ROUTE_W'(FIXED_LINE)
                                          : timerRoute[t*ROUTE_W +: ROUTE_W];
    end else begin : g_plain
      assign effRoute[t] = timerRoute[t*ROUTE_W +: ROUTE_W];
    end
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      assign hitVec[t][l] = timerIrq[t] && (effRoute[t] == ROUTE_W'(l));
    end
  end

  always_comb begin
    timerOr = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      timerOr = timerOr | hitVec[t];
    end
  end

  // clock contribution to its reserved line
  always_comb begin
    if (ctrlS.legacyFall)      clkNext = ctrlS.heldLevel;
    else if (ctrlS.legacyRise) clkNext = 1'b0;
    else if (ctrlS.legacyOn)   clkNext = 1'b0;
    else                       clkNext = rtcIrq;
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_clk
    if (l == CLK_LINE) begin : g_on
      assign clockVec[l] = clkNext;
    end else begin : g_off
      assign clockVec[l] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irqLines <= '0;
    else     irqLines <= timerOr | clockVec;
  end
endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
  import tlr_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_LINES  = 24,
  parameter int ROUTE_W    = 5,
  parameter int T0_LINE    = 0,
  parameter int CLK_LINE   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          legacyEn,
  input  logic                          rtcIrq,
  input  logic [NUM_TIMERS-1:0]         timerIrq,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] timerRoute,
  output logic [NUM_LINES-1:0]          irqLines
);
  tlrCtrl_t ctrlS;

  tlr_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .legacyEn (legacyEn),
    .rtcIrq   (rtcIrq),
    .ctrlS    (ctrlS)
  );

  tlr_datapath #(
    .NUM_TIMERS (NUM_TIMERS),
    .NUM_LINES  (NUM_LINES),
    .ROUTE_W    (ROUTE_W),
    .T0_LINE    (T0_LINE),
    .CLK_LINE   (CLK_LINE)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .ctrlS      (ctrlS),
    .rtcIrq     (rtcIrq),
    .timerIrq   (timerIrq),
    .timerRoute (timerRoute),
    .irqLines   (irqLines)
  );
endmodule

// File: rtl/timer_irq_router_chk.sv
module timer_irq_router_chk #(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_LINES  = 24,
  parameter int ROUTE_W    = 5,
  parameter int T0_LINE    = 0,
  parameter int CLK_LINE   = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          legacyEn,
  input logic                          rtcIrq,
  input logic [NUM_TIMERS-1:0]         timerIrq,
  input logic [NUM_TIMERS*ROUTE_W-1:0] timerRoute,
  input logic [NUM_LINES-1:0]          irqLines
);
  logic prevLeg;
  logic storedLvl;
  logic pastRst;
  logic otherHit8;
  logic anyHit8;

  always_ff @(posedge clk) begin
    pastRst <= rst;
    if (rst) begin
      prevLeg   <= 1'b0;
      storedLvl <= 1'b0;
    end else begin
      prevLeg   <= legacyEn;
      storedLvl <= rtcIrq;
    end
  end

  // timers 2+ aimed at the clock line
  always_comb begin
    otherHit8 = 1'b0;
    for (int t = 2; t < NUM_TIMERS; t++) begin
      if (timerIrq[t] && timerRoute[t*ROUTE_W +: ROUTE_W] == ROUTE_W'(CLK_LINE))
        otherHit8 = 1'b1;
    end
  end

  always_comb begin
    anyHit8 = otherHit8;
    if (legacyEn) begin
      if (timerIrq[1]) anyHit8 = 1'b1;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (timerIrq[t] && timerRoute[t*ROUTE_W +: ROUTE_W] == ROUTE_W'(CLK_LINE))
          anyHit8 = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pastRst) begin
      AST_RESET_CLEAR: assert (irqLines == '0); // R1
    end
  end

  AST_LEGACY_T0: assert property (@(posedge clk) disable iff (rst)
    legacyEn && timerIrq[0] |=> irqLines[T0_LINE]); // R3

  AST_LEGACY_T1: assert property (@(posedge clk) disable iff (rst)
    legacyEn && timerIrq[1] |=> irqLines[CLK_LINE]); // R3

  AST_CLK_PASS: assert property (@(posedge clk) disable iff (rst)
    !legacyEn && !prevLeg && rtcIrq |=> irqLines[CLK_LINE]); // R5

  AST_CLK_MASK: assert property (@(posedge clk) disable iff (rst)
    legacyEn && !timerIrq[1] && !otherHit8 |=> !irqLines[CLK_LINE]); // R6

  AST_CLK_RESTORE: assert property (@(posedge clk) disable iff (rst)
    !legacyEn && prevLeg && !anyHit8 |=> irqLines[CLK_LINE] == $past(storedLvl)); // R7

  AST_QUIET_LEGACY: assert property (@(posedge clk) disable iff (rst)
    legacyEn && timerIrq == '0 |=> irqLines == '0); // R6
endmodule

bind timer_irq_router timer_irq_router_chk #(
  .NUM_TIMERS (NUM_TIMERS),
  .NUM_LINES  (NUM_LINES),
  .ROUTE_W    (ROUTE_W),
  .T0_LINE    (T0_LINE),
  .CLK_LINE   (CLK_LINE)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .legacyEn   (legacyEn),
  .rtcIrq     (rtcIrq),
  .timerIrq   (timerIrq),
  .timerRoute (timerRoute),
  .irqLines   (irqLines)
);

// File: tb/timer_irq_router_tb_top.sv
module timer_irq_router_tb_top;
  localparam int NT = 4;
  localparam int NL = 24;
  localparam int RW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            legacyEn = 1'b0;
  logic            rtcIrq = 1'b0;
  logic [NT-1:0]   timerIrq = '0;
  logic [NT*RW-1:0] timerRoute = '0;
  logic [NL-1:0]   irqLines;

  int vecCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  // bench model state
  bit mPrevLeg = 1'b0;
  bit mStored  = 1'b0;

  always #5 clk = ~clk;

  timer_irq_router dut_i (
    .clk        (clk),
    .rst        (rst),
    .legacyEn   (legacyEn),
    .rtcIrq     (rtcIrq),
    .timerIrq   (timerIrq),
    .timerRoute (timerRoute),
    .irqLines   (irqLines)
  );

  function automatic logic [NT*RW-1:0] packRoutes(int r0, int r1, int r2, int r3);
    logic [NT*RW-1:0] v;
    v = {RW'(r3), RW'(r2), RW'(r1), RW'(r0)};
    return v;
  endfunction

  function automatic logic [NL-1:0] expectLines(logic [NT-1:0] irq, logic [NT*RW-1:0] rt,
                                                bit leg, bit pLeg, bit held, bit rtc);
    logic [NL-1:0] e;
    int line;
    bit clkBit;
    e = '0;
    for (int t = 0; t < NT; t++) begin
      if (leg && t == 0)      line = 0;
      else if (leg && t == 1) line = 8;
      else                    line = int'(rt[t*RW +: RW]);
      if (irq[t] && line < NL) e[line] = 1'b1;
    end
    if (leg)       clkBit = 1'b0;
    else if (pLeg) clkBit = held;
    else           clkBit = rtc;
    if (clkBit) e[8] = 1'b1;
    return e;
  endfunction

  task automatic applyVec(logic [NT-1:0] irq, logic [NT*RW-1:0] rt, bit leg, bit rtc,
                          string tag);
    logic [NL-1:0] exp;
    @(negedge clk);
    timerIrq   = irq;
    timerRoute = rt;
    legacyEn   = leg;
    rtcIrq     = rtc;
    exp = expectLines(irq, rt, leg, mPrevLeg, mStored, rtc);
    @(posedge clk);
    #1;
    mPrevLeg = leg;
    mStored  = rtc;
    vecCount++;
    if (irqLines !== exp) begin
      failCount++;
      $display("FAIL %s: irqLines=%06h expected=%06h", tag, irqLines, exp);
    end
  endtask

  task automatic resetCheck();
    @(negedge clk);
    rst = 1'b1;
    timerIrq = '1;
    rtcIrq = 1'b1;
    legacyEn = 1'b1;
    @(posedge clk);
    #1;
    vecCount++;
    if (irqLines !== '0) begin
      failCount++;
      $display("FAIL R1: irqLines=%06h expected=000000", irqLines);
    end
    @(negedge clk);
    timerIrq = '0;
    rtcIrq = 1'b0;
    legacyEn = 1'b0;
    @(posedge clk);
    #1;
    mPrevLeg = 1'b0;
    mStored  = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    resetCheck();
    // R2: plain routing, OR of two timers on one line
    applyVec(4'b0001, packRoutes(5, 0, 0, 0), 1'b0, 1'b0, "R2");
    applyVec(4'b1001, packRoutes(12, 0, 0, 12), 1'b0, 1'b0, "R2");
    applyVec(4'b0110, packRoutes(0, 23, 17, 0), 1'b0, 1'b0, "R2");
    // R3: legacy pins timers 0 and 1
    applyVec(4'b0011, packRoutes(5, 3, 0, 0), 1'b1, 1'b0, "R3");
    applyVec(4'b0001, packRoutes(20, 20, 0, 0), 1'b1, 1'b0, "R3");
    // R4: upper timers keep route in legacy mode
    applyVec(4'b1100, packRoutes(0, 0, 8, 2), 1'b1, 1'b0, "R4");
    // R8: out-of-range routes drop
    applyVec(4'b1111, packRoutes(24, 31, 25, 30), 1'b0, 1'b0, "R8");
    // R5: clock pass-through, then ORed with timer on line 8
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b0, 1'b1, "R5");
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b0, 1'b0, "R5");
    applyVec(4'b0100, packRoutes(0, 0, 8, 0), 1'b0, 1'b1, "R5");
    // R6: rise with clock high masks it, stays masked
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b0, 1'b1, "R5");
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b1, 1'b1, "R6");
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b1, 1'b1, "R6");
    // R7: fall with clock dropping the same cycle -> stored 1
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b0, 1'b0, "R7");
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b0, 1'b0, "R5");
    // R7: stored 0 while legacy, clock rises at the fall -> 0
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b1, 1'b1, "R6");
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b1, 1'b0, "R6");
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b0, 1'b1, "R7");
    applyVec(4'b0000, packRoutes(0, 0, 0, 0), 1'b0, 1'b1, "R5");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [NT-1:0] rIrq;
      logic [NT*RW-1:0] rRt;
      bit rLeg;
      bit rRtc;
      rIrq = NT'($urandom);
      rRt  = (NT*RW)'($urandom);
      rLeg = ($urandom % 4) == 0 ? ~legacyEn : legacyEn;
      rRtc = 1'($urandom);
      applyVec(rIrq, rRt, rLeg, rRtc, "R2/R7 random");
    end
    resetCheck();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule